// File: doc/BRIEF.md
# Involutive 32-bit Substitution-Permutation Network

This block is a keyless 32-bit mixing network for one half of a block cipher state. The word is split into eight nibbles, and each nibble goes through its own 4-bit substitution. The bits are then rearranged by a fixed chain of wire permutations. A final layer applies the inverse of each nibble's substitution. Because the chain is built symmetrically, the whole mapping is its own inverse. The same hardware therefore serves both directions of a cipher: a second pass through the network restores the original word.

A parameter selects whether the result leaves the block straight from the combinational network or through one output register. Round sequencing and key mixing belong to the surrounding datapath.

Top module: `spn_invol_box`

## Requirements
- R1: Nibble n (n = 0 for bits 31..28, up to n = 7 for bits 3..0) is substituted by table n in the first layer. Table n is the first row (outer bits 00) of the n-th of the eight classic 6-to-4 DES substitution boxes, indexed by the nibble value.
- R2: The first permutation stage and its inverse stage use the 4-cycles (1,3,19,17)(2,7,20,21)(4,23,18,5)(6,8,24,22)(11,27,25,9)(10,15,28,29)(12,31,26,13)(14,16,32,30). Positions are numbered 1..32 from the most significant bit. A cycle (a,b,...) means the bit at position a moves to position b. The inverse stage moves every bit one step backward along its cycle.
- R3: The second and fourth stages swap bit pairs (2,5)(3,9)(4,13)(7,10)(8,14)(12,15)(18,21)(19,25)(20,29)(23,26)(24,30)(28,31). All other positions are unchanged.
- R4: The middle stage swaps bit pairs (2,5)(3,17)(4,21)(7,18)(8,22)(10,13)(11,25)(12,29)(15,26)(16,30)(20,23)(28,31). All other positions are unchanged.
- R5: The stages run in this order: forward substitution, cycle stage, first swap stage, middle swap stage, first swap stage again, inverse cycle stage, inverse substitution.
- R6: For every input x, applying the network to its own output gives x back.
- R7: With OUT_REG = 1, `dout` shows the mapping of the `din` sampled at the previous rising clock edge. A low `rst_n` at a rising edge clears `dout` to zero at that edge.
- R8: With OUT_REG = 0, `dout` is the mapping of the current `din` within the same cycle, with no register.
- R9: Each of the eight substitution tables is a bijection on 4-bit values. The last layer's table for nibble n maps every output of table n back to its input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 32 | Input word |
| dout | output | 32 | Mapped word (registered or combinational per OUT_REG) |

## Verification
The bench builds two copies of the block side by side. One uses OUT_REG = 1 and the other OUT_REG = 0, so a single stimulus stream checks the one-cycle registered path and the zero-latency combinational path against the same expected value. The registered copy also carries the reset-clear and the feed-back test for the involution: its output is fed back as the next input and must come back as the original word. Single-bit and per-nibble sweep vectors bring each permutation cycle and every entry of every table within reach. The random words then test the full stage order.

// File: rtl/spn_invol_pkg.sv
// Shared constants and constant functions for the involutive SPN.
// Assumes a 32-bit word of eight 4-bit nibbles; positions 1..32 count from the MSB.
package spn_invol_pkg;

    localparam int BITS  = 32;
    localparam int NIB   = 4;
    localparam int NBOX  = BITS / NIB;
    localparam int NCYC  = 8;
    localparam int CLEN  = 4;
    localparam int NSWP  = 12;

    typedef enum logic [1:0] {
        PERM_CYC  = 2'd0,
        PERM_SWPA = 2'd1,
        PERM_SWPB = 2'd2
    } perm_sel_e;

    localparam int CYC_TAB [NCYC][CLEN] = '{
        '{1, 3, 19, 17}, '{2, 7, 20, 21}, '{4, 23, 18, 5}, '{6, 8, 24, 22},
        '{11, 27, 25, 9}, '{10, 15, 28, 29}, '{12, 31, 26, 13}, '{14, 16, 32, 30}
    };

    localparam int SWPA_TAB [NSWP][2] = '{
        '{2, 5}, '{3, 9}, '{4, 13}, '{7, 10}, '{8, 14}, '{12, 15},
        '{18, 21}, '{19, 25}, '{20, 29}, '{23, 26}, '{24, 30}, '{28, 31}
    };

    localparam int SWPB_TAB [NSWP][2] = '{
        '{2, 5}, '{3, 17}, '{4, 21}, '{7, 18}, '{8, 22}, '{10, 13},
        '{11, 25}, '{12, 29}, '{15, 26}, '{16, 30}, '{20, 23}, '{28, 31}
    };

    // Forward table: nibble-packed, entry for input v sits at bits [63-4v -: 4].
    function automatic logic [NIB-1:0] sbox_fwd(input int box, input logic [NIB-1:0] x);
        logic [63:0] t;
        case (box)
            0:       t = 64'hE4D12FB83A6C5907;
            1:       t = 64'hF18E6B34972DC05A;
            2:       t = 64'hA09E63F51DC7B428;
            3:       t = 64'h7DE3069A1285BC4F;
            4:       t = 64'h2C417AB6853FD0E9;
            5:       t = 64'hC1AF92680D34E75B;
            6:       t = 64'h4B2EF08D3C975A61;
            default: t = 64'hD2846FB1A93E50C7;
        endcase
        return t[63 - NIB*int'(x) -: NIB];
    endfunction

    // Inverse table derived by search over the forward table.
    function automatic logic [NIB-1:0] sbox_inv(input int box, input logic [NIB-1:0] y);
        logic [NIB-1:0] r;
        r = '0;
        for (int v = 0; v < (1 << NIB); v++) begin
            if (sbox_fwd(box, NIB'(v)) == y) r = NIB'(v);
        end
        return r;
    endfunction

    // Position (1-based) whose bit lands on position pos for the chosen stage.
    function automatic int perm_src(input perm_sel_e sel, input bit inv, input int pos);
        int r;
        r = pos;
        if (sel == PERM_CYC) begin
            for (int j = 0; j < NCYC; j++)
                for (int k = 0; k < CLEN; k++)
                    if (CYC_TAB[j][k] == pos)
                        r = inv ? CYC_TAB[j][(k + 1) % CLEN] : CYC_TAB[j][(k + CLEN - 1) % CLEN];
        end else begin
            for (int j = 0; j < NSWP; j++) begin
                if (sel == PERM_SWPA) begin
                    if (SWPA_TAB[j][0] == pos) r = SWPA_TAB[j][1];
                    if (SWPA_TAB[j][1] == pos) r = SWPA_TAB[j][0];
                end else begin
                    if (SWPB_TAB[j][0] == pos) r = SWPB_TAB[j][1];
                    if (SWPB_TAB[j][1] == pos) r = SWPB_TAB[j][0];
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/spn_sbox_layer.sv
// Eight parallel 4-bit substitutions, forward or inverse per INV.
// Assumes nibble 0 is the most significant nibble and uses table 0.
module spn_sbox_layer
    import spn_invol_pkg::*;
#(
    parameter bit INV = 1'b0
) (
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] dout
);

    for (genvar b = 0; b < NBOX; b++) begin : g_box
        localparam int HI = BITS - 1 - NIB*b;
        logic [NIB-1:0] nib_in;
        assign nib_in = din[HI -: NIB];

        if (INV) begin : g_inv
            assign dout[HI -: NIB] = sbox_inv(b, nib_in);
        end else begin : g_fwd
            assign dout[HI -: NIB] = sbox_fwd(b, nib_in);
        end

        // Guard: the inverse table undoes the forward table on live data.
        always_comb begin
            AST_SBOX_ROUNDTRIP: assert (sbox_inv(b, sbox_fwd(b, nib_in)) == nib_in); // R9
        end
    end

endmodule

// File: rtl/spn_bit_perm.sv
// Fixed wire permutation of a 32-bit word, stage chosen by SEL, reversed by INV.
// Assumes positions 1..32 from the MSB; pure wiring, no logic.
module spn_bit_perm
    import spn_invol_pkg::*;
#(
    parameter perm_sel_e SEL = PERM_CYC,
    parameter bit        INV = 1'b0
) (
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] dout
);

    for (genvar p = 1; p <= BITS; p++) begin : g_pos
        localparam int SRC = perm_src(SEL, INV, p);
        assign dout[BITS-p] = din[BITS-SRC];
    end

    // Guard: a permutation keeps the number of set bits.
    always_comb begin
        AST_PERM_WEIGHT: assert ($countones(dout) == $countones(din)); // R2
    end

endmodule

// File: rtl/spn_core.sv
// Combinational seven-stage network: S, cycle, swapA, swapB, swapA, cycle^-1, S^-1.
// Assumes the stage order above; that symmetry makes the mapping self-inverse.
module spn_core
    import spn_invol_pkg::*;
(
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] dout
);

    logic [BITS-1:0] st_sub, st_cyc, st_sa, st_sb, st_sa2, st_cyci;

    spn_sbox_layer #(.INV(1'b0)) u_sub_f (.din(din), .dout(st_sub));
    spn_bit_perm #(.SEL(PERM_CYC), .INV(1'b0)) u_cyc_f (.din(st_sub), .dout(st_cyc));
    spn_bit_perm #(.SEL(PERM_SWPA), .INV(1'b0)) u_swa_0 (.din(st_cyc), .dout(st_sa));
    spn_bit_perm #(.SEL(PERM_SWPB), .INV(1'b0)) u_swb (.din(st_sa), .dout(st_sb));
    spn_bit_perm #(.SEL(PERM_SWPA), .INV(1'b0)) u_swa_1 (.din(st_sb), .dout(st_sa2));
    spn_bit_perm #(.SEL(PERM_CYC), .INV(1'b1)) u_cyc_i (.din(st_sa2), .dout(st_cyci));
    spn_sbox_layer #(.INV(1'b1)) u_sub_i (.din(st_cyci), .dout(dout));

endmodule

// File: rtl/spn_invol_box.sv
// Top: involutive SPN with optional output register (OUT_REG).
// Assumes synchronous active-low reset; register clears to zero.
module spn_invol_box
    import spn_invol_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] dout
);

    logic [BITS-1:0] core_y;
    logic [BITS-1:0] chk_y;

    spn_core u_core (.din(din), .dout(core_y));

    // Second pass used only to watch the self-inverse property.
    spn_core u_chk (.din(core_y), .dout(chk_y));

    AST_INVOLUTION: assert property (@(posedge clk) disable iff (!rst_n)
        chk_y == din); // R6

    if (OUT_REG) begin : g_reg
        // Capture the network result each cycle; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) dout <= '0;
            else        dout <= core_y;
        end

        AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(din)) |=> $stable(dout)); // R7
    end else begin : g_comb
        assign dout = core_y;
    end

endmodule

// File: tb/spn_invol_box_tb.sv
// Self-checking bench: registered and combinational copies against a bench model.
module spn_invol_box_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] dout_r, dout_c;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    spn_invol_box #(.OUT_REG(1'b1)) dut_i (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout_r));
    spn_invol_box #(.OUT_REG(1'b0)) dut_c (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout_c));

    localparam int TB_CYC [8][4] = '{
        '{1, 3, 19, 17}, '{2, 7, 20, 21}, '{4, 23, 18, 5}, '{6, 8, 24, 22},
        '{11, 27, 25, 9}, '{10, 15, 28, 29}, '{12, 31, 26, 13}, '{14, 16, 32, 30}
    };
    localparam int TB_SA [12][2] = '{
        '{2, 5}, '{3, 9}, '{4, 13}, '{7, 10}, '{8, 14}, '{12, 15},
        '{18, 21}, '{19, 25}, '{20, 29}, '{23, 26}, '{24, 30}, '{28, 31}
    };
    localparam int TB_SB [12][2] = '{
        '{2, 5}, '{3, 17}, '{4, 21}, '{7, 18}, '{8, 22}, '{10, 13},
        '{11, 25}, '{12, 29}, '{15, 26}, '{16, 30}, '{20, 23}, '{28, 31}
    };

    // R1: first rows of the DES boxes, in box order.
    function automatic logic [3:0] tb_sbox(input int box, input int v);
        logic [63:0] t;
        case (box)
            0: t = 64'hE4D12FB83A6C5907;
            1: t = 64'hF18E6B34972DC05A;
            2: t = 64'hA09E63F51DC7B428;
            3: t = 64'h7DE3069A1285BC4F;
            4: t = 64'h2C417AB6853FD0E9;
            5: t = 64'hC1AF92680D34E75B;
            6: t = 64'h4B2EF08D3C975A61;
            default: t = 64'hD2846FB1A93E50C7;
        endcase
        return t[63 - 4*v -: 4];
    endfunction

    function automatic logic [31:0] tb_sub(input logic [31:0] x, input bit inv);
        logic [31:0] y = '0;
        for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 16; v++) begin
                if (!inv && x[31-4*b -: 4] == 4'(v)) y[31-4*b -: 4] = tb_sbox(b, v);
                if (inv && tb_sbox(b, v) == x[31-4*b -: 4]) y[31-4*b -: 4] = 4'(v);
            end
        end
        return y;
    endfunction

    // Move bits along cycles: bit at position a goes to the next element.
    function automatic logic [31:0] tb_cyc(input logic [31:0] x, input bit inv);
        logic [31:0] y = x;
        for (int j = 0; j < 8; j++)
            for (int k = 0; k < 4; k++) begin
                if (!inv) y[32 - TB_CYC[j][(k+1)%4]] = x[32 - TB_CYC[j][k]];
                else      y[32 - TB_CYC[j][k]] = x[32 - TB_CYC[j][(k+1)%4]];
            end
        return y;
    endfunction

    function automatic logic [31:0] tb_swap(input logic [31:0] x, input bit second);
        logic [31:0] y = x;
        for (int j = 0; j < 12; j++) begin
            int a = second ? TB_SB[j][0] : TB_SA[j][0];
            int c = second ? TB_SB[j][1] : TB_SA[j][1];
            y[32-a] = x[32-c];
            y[32-c] = x[32-a];
        end
        return y;
    endfunction

    // R5: stage order of the whole network.
    function automatic logic [31:0] model(input logic [31:0] x);
        logic [31:0] y;
        y = tb_sub(x, 1'b0);
        y = tb_cyc(y, 1'b0);
        y = tb_swap(y, 1'b0);
        y = tb_swap(y, 1'b1);
        y = tb_swap(y, 1'b0);
        y = tb_cyc(y, 1'b1);
        y = tb_sub(y, 1'b1);
        return y;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [31:0] x, input string tag);
        @(negedge clk);
        din = x;
        #1;
        check(dout_c, model(x), {tag, " comb R8"});
        @(negedge clk);
        check(dout_r, model(x), {tag, " reg R7"});
    endtask

    task automatic run_invol(input logic [31:0] x);
        logic [31:0] y;
        run_vec(x, "R6 pass1 R5");
        y = dout_r;
        @(negedge clk);
        din = y;
        @(negedge clk);
        check(dout_r, x, "R6 second pass");
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        check(dout_r, 32'h0, "R7 reset state");
        rst_n = 1'b1;

        // R9: bench tables are bijections and inverse lookup undoes forward.
        for (int b = 0; b < 8; b++) begin
            logic [15:0] seen = '0;
            for (int v = 0; v < 16; v++) seen[tb_sbox(b, v)] = 1'b1;
            check({16'h0, seen}, 32'h0000FFFF, "R9 table bijective");
        end
        for (int v = 0; v < 16; v++) begin
            logic [31:0] w = {8{4'(v)}};
            check(tb_sub(tb_sub(w, 1'b0), 1'b1), w, "R9 inverse table");
        end

        // R1: every nibble value in every nibble position.
        for (int v = 0; v < 16; v++) run_vec({8{4'(v)}}, "R1 nibble sweep");
        // R2/R3/R4: one-hot words follow each bit through the permutations.
        for (int p = 0; p < 32; p++) run_vec(32'h1 << p, "R2 R3 R4 one-hot");
        run_vec(32'hFFFF_FFFF, "R5 all ones");
        run_vec(32'h0123_4567, "R5 ramp");

        for (int i = 0; i < 8; i++) run_invol({8{4'(i)}});
        for (int i = 0; i < 200; i++) run_invol($urandom);

        // R7: reset in mid-run clears the register.
        @(negedge clk);
        din = 32'hDEAD_BEEF;
        @(negedge clk);
        check(dout_r, model(32'hDEAD_BEEF), "R7 before reset");
        rst_n = 1'b0;
        @(negedge clk);
        check(dout_r, 32'h0, "R7 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_r, model(32'hDEAD_BEEF), "R7 after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule